// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is a single memory-to-memory copy channel driven entirely by descriptors held in memory. Software places a six-word descriptor in memory, writes its address into the channel's window and sets the run bit. The channel then reads the descriptor and copies the byte count it names from the source to the destination, one beat at a time. It groups beats into bursts, may idle between bursts, and either steps or holds each address. When a descriptor's bytes are done it raises a one-cycle end-of-package pulse. It then either fetches the descriptor named by the link word, or stops when the link equals the end-of-chain marker 0xFFFFF800.

The descriptor words sit at consecutive word addresses in this order: configuration, source address, destination address, byte count, parameter, link. All words are little-endian. Three independent ports carry the traffic: a descriptor read port, a data read port and a data write port. Each port uses a request/acknowledge handshake in which the request is held until it is acknowledged. Data travels in the low byte lanes of the 32-bit buses, and a size code gives the number of valid bytes. Peripheral request-type fields are loaded with the configuration word but have no effect on the copy.

Top module: `dma_chain_engine`

## Requirements
- R1: Writing 1 to bit 0 of the run register (word index 0, byte offset 0x00) while the channel is idle makes busy high. The channel then reads six words at descriptor address, descriptor address + 4, and so on up to + 20. The descriptor address is taken from the start register (word index 2) and must be a multiple of 4.
- R2: Register reads are selected by word index (byte offset / 4). Index 0 reads the run bit and index 1 the hold bit. Index 2 reads the start address and index 3 the loaded configuration word. Indexes 4, 5 and 6 read the current source address, the current destination address and the bytes left. Index 7 reads the parameter word. All of them read 0 after reset.
- R3: Two configuration fields give the source width (bits 10:9) and the destination width (bits 26:25), each coded 0/1/2/3 for 8/16/32/64 bits. One beat moves the smaller of the two widths, with 64 bits limited to 32. The size outputs carry 0, 1 or 2 for 1, 2 or 4 bytes.
- R4: When fewer bytes are left than the beat unit, the remaining bytes move as 1-byte beats.
- R5: Bit 5 of the configuration word controls the source address and bit 21 controls the destination address. A value of 0 advances the address by the beat's byte count after each beat. A value of 1 keeps the address fixed.
- R6: The source burst code in bits 7:6 is coded 0/1/2/3 for 1/4/8/16 beats. After each complete burst, if bytes remain, the channel idles for the number of cycles in parameter bits 7:0.
- R7: pkg_end pulses for one cycle after each descriptor's byte count reaches zero. This includes a descriptor whose count is already zero.
- R8: A link other than 0xFFFFF800 is fetched as the next descriptor. A link equal to it raises queue_end together with pkg_end, after which busy drops and the run bit reads 0.
- R9: While the hold bit (word index 1, bit 0) is 1, no new read starts, and the addresses and bytes left keep their values. A read already requested is completed. Clearing the bit resumes the copy.
- R10: Writing 0 to the run bit returns the channel to idle on the next cycle. It drops every request. No further write or pkg_end follows, and the bytes-left value is frozen.
- R11: At most one of the three ports requests at a time. A data read request stays high until acknowledged unless the channel is stopped.
- R12: Writing 1 to the run bit while the channel is busy has no effect on the running chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_word | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_word |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | 32 | Descriptor word address |
| dsc_ack | input | 1 | Descriptor read acknowledge |
| dsc_data | input | 32 | Descriptor word |
| rd_req | output | 1 | Data read request |
| rd_addr | output | 32 | Data read address |
| rd_size | output | 2 | Data read size code |
| rd_ack | input | 1 | Data read acknowledge |
| rd_data | input | 32 | Data read value, low lanes |
| wr_req | output | 1 | Data write request |
| wr_addr | output | 32 | Data write address |
| wr_size | output | 2 | Data write size code |
| wr_data | output | 32 | Data write value, low lanes |
| wr_ack | input | 1 | Data write acknowledge |
| busy | output | 1 | Channel not idle |
| pkg_end | output | 1 | One-cycle end-of-descriptor pulse |
| queue_end | output | 1 | One-cycle end-of-chain pulse |

## Verification
The assertions assume that software gives only word-aligned descriptor and link addresses. They also assume that every memory acknowledge answers a request that is high in the same cycle. The bench keeps to both conditions. Every descriptor it builds sits on a multiple of 4. Its memory model derives each acknowledge from the request it sampled half a cycle earlier and commits a write only once per request. Byte counts in the sweeps are multiples of the beat unit, except in the run that exercises the remainder path.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter logic [31:0] END_PTR = 32'hFFFF_F800,
  parameter int WAIT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_word,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        dsc_req,
  output logic [31:0] dsc_addr,
  input  logic        dsc_ack,
  input  logic [31:0] dsc_data,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  output logic [1:0]  rd_size,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        wr_req,
  output logic [31:0] wr_addr,
  output logic [1:0]  wr_size,
  output logic [31:0] wr_data,
  input  logic        wr_ack,
  output logic        busy,
  output logic        pkg_end,
  output logic        queue_end
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_GAP, S_PKG} st_t;

  st_t st;
  logic              en_q, pause_q, rd_live_q;
  logic [31:0]       start_q, cfg_q, src_q, dst_q, left_q, par_q, nxt_q, dptr_q, buf_q;
  logic [2:0]        widx_q;
  logic [4:0]        beat_q;
  logic [WAIT_W-1:0] gap_q;

  logic [1:0]  narrow, ucode, step_code;
  logic [2:0]  unit, step;
  logic [4:0]  burst;
  logic [31:0] step32;
  logic        big, s_fix, d_fix;

  assign narrow    = (cfg_q[10:9] < cfg_q[26:25]) ? cfg_q[10:9] : cfg_q[26:25];
  assign ucode     = (narrow == 2'd3) ? 2'd2 : narrow;
  assign unit      = 3'd1 << ucode;
  assign big       = left_q >= {29'd0, unit};
  assign step_code = big ? ucode : 2'd0;
  assign step      = big ? unit : 3'd1;
  assign step32    = {29'd0, step};
  assign s_fix     = cfg_q[5];
  assign d_fix     = cfg_q[21];
  assign burst     = (cfg_q[7:6] == 2'd0) ? 5'd1 : (5'd2 << cfg_q[7:6]);

  assign dsc_req   = (st == S_FETCH);
  assign dsc_addr  = dptr_q + {27'd0, widx_q, 2'b00};
  assign rd_req    = (st == S_RD) && (rd_live_q || !pause_q);
  assign rd_addr   = src_q;
  assign rd_size   = step_code;
  assign wr_req    = (st == S_WR);
  assign wr_addr   = dst_q;
  assign wr_size   = step_code;
  assign wr_data   = buf_q;
  assign busy      = (st != S_IDLE);
  assign pkg_end   = (st == S_PKG);
  assign queue_end = (st == S_PKG) && (nxt_q == END_PTR);

  always_comb begin
    case (cfg_word)
      4'd0:    cfg_rdata = {31'd0, en_q};
      4'd1:    cfg_rdata = {31'd0, pause_q};
      4'd2:    cfg_rdata = start_q;
      4'd3:    cfg_rdata = cfg_q;
      4'd4:    cfg_rdata = src_q;
      4'd5:    cfg_rdata = dst_q;
      4'd6:    cfg_rdata = left_q;
      4'd7:    cfg_rdata = par_q;
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      en_q      <= 1'b0;
      pause_q   <= 1'b0;
      rd_live_q <= 1'b0;
      start_q   <= '0;
      cfg_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      left_q    <= '0;
      par_q     <= '0;
      nxt_q     <= '0;
      dptr_q    <= '0;
      buf_q     <= '0;
      widx_q    <= '0;
      beat_q    <= '0;
      gap_q     <= '0;
    end else begin
      case (st)
        S_FETCH: if (dsc_ack) begin
          case (widx_q)
            3'd0:    cfg_q  <= dsc_data;
            3'd1:    src_q  <= dsc_data;
            3'd2:    dst_q  <= dsc_data;
            3'd3:    left_q <= dsc_data;
            3'd4:    par_q  <= dsc_data;
            default: nxt_q  <= dsc_data;
          endcase
          if (widx_q == 3'd5) st <= S_CHECK;
          else widx_q <= widx_q + 3'd1;
        end
        S_CHECK: begin
          beat_q <= '0;
          st     <= (left_q == 32'd0) ? S_PKG : S_RD;
        end
        S_RD: begin
          rd_live_q <= rd_req && !rd_ack;
          if (rd_req && rd_ack) begin
            buf_q <= rd_data;
            st    <= S_WR;
          end
        end
        S_WR: if (wr_ack) begin
          left_q <= left_q - step32;
          if (!s_fix) src_q <= src_q + step32;
          if (!d_fix) dst_q <= dst_q + step32;
          if (left_q == step32) st <= S_PKG;
          else if (beat_q + 5'd1 == burst) begin
            beat_q <= '0;
            if (par_q[WAIT_W-1:0] != '0) begin
              gap_q <= par_q[WAIT_W-1:0];
              st    <= S_GAP;
            end else st <= S_RD;
          end else begin
            beat_q <= beat_q + 5'd1;
            st     <= S_RD;
          end
        end
        S_GAP: begin
          gap_q <= gap_q - 1'b1;
          if (gap_q == {{(WAIT_W-1){1'b0}}, 1'b1}) st <= S_RD;
        end
        S_PKG: if (nxt_q == END_PTR) begin
          st   <= S_IDLE;
          en_q <= 1'b0;
        end else begin
          dptr_q <= nxt_q;
          widx_q <= '0;
          st     <= S_FETCH;
        end
        default: ;
      endcase

      if (cfg_we) begin
        case (cfg_word)
          4'd0: begin
            if (!cfg_wdata[0]) begin
              en_q      <= 1'b0;
              rd_live_q <= 1'b0;
              st        <= S_IDLE;
            end else if (st == S_IDLE) begin
              en_q   <= 1'b1;
              dptr_q <= start_q;
              widx_q <= '0;
              st     <= S_FETCH;
            end
          end
          4'd1:    pause_q <= cfg_wdata[0];
          4'd2:    start_q <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

module dma_chain_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        dsc_req,
  input logic [1:0]  dsc_lo,
  input logic        rd_req,
  input logic        rd_ack,
  input logic        wr_req,
  input logic        wr_ack,
  input logic [1:0]  wr_size,
  input logic        pkg_end,
  input logic        queue_end,
  input logic        en_q,
  input logic [31:0] left_q
);

  AST_DSC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_req |-> dsc_lo == 2'b00); // R1

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_size != 2'd3); // R3

  AST_LEFT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> left_q < $past(left_q)); // R3

  AST_QEND_WITH_PKG: assert property (@(posedge clk) disable iff (!rst_n)
    queue_end |-> pkg_end); // R8

  AST_QEND_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    queue_end |=> !en_q && !busy); // R8

  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req && !rd_req |=> !wr_req); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dsc_req || rd_req || wr_req)); // R10

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dsc_req, rd_req, wr_req})); // R11

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req || !en_q); // R11

endmodule

bind dma_chain_engine dma_chain_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dsc_req(dsc_req), .dsc_lo(dsc_addr[1:0]),
  .rd_req(rd_req), .rd_ack(rd_ack), .wr_req(wr_req), .wr_ack(wr_ack), .wr_size(wr_size),
  .pkg_end(pkg_end), .queue_end(queue_end), .en_q(en_q), .left_q(left_q)
);

// File: tb/sim_dma_chain_engine.sv
module sim_dma_chain_engine;
  localparam logic [31:0] ENDP = 32'hFFFF_F800;
  localparam int SRC = 32'h200;
  localparam int DST = 32'h300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dsc_req, rd_req, wr_req, busy, pkg_end, queue_end;
  logic [31:0] dsc_addr, rd_addr, wr_addr, wr_data;
  logic [1:0]  rd_size, wr_size;
  logic        dsc_ack = 1'b0, rd_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] dsc_data = '0, rd_data = '0;

  dma_chain_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack),
    .dsc_data(dsc_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy),
    .pkg_end(pkg_end), .queue_end(queue_end)
  );

  logic [7:0] mem [0:2047];
  int cyc = 0, n_chk = 0, n_bad = 0;
  int pkg_cnt = 0, qend_cnt = 0, wr_cnt = 0, dsc_cnt = 0, multi_cnt = 0;

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return {mem[(a + 3) & 2047], mem[(a + 2) & 2047], mem[(a + 1) & 2047], mem[a & 2047]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (dsc_req) dsc_cnt++;
    if (int'(dsc_req) + int'(rd_req) + int'(wr_req) > 1) multi_cnt++;
    if (pkg_end) pkg_cnt++;
    if (queue_end) qend_cnt++;
    if (wr_req && !wr_ack) begin
      wr_cnt++;
      for (int j = 0; j < (1 << wr_size); j++) mem[(wr_addr + j) & 2047] = wr_data[8*j +: 8];
    end
    dsc_ack <= dsc_req; dsc_data <= rdw(dsc_addr);
    rd_ack  <= rd_req;  rd_data  <= rdw(rd_addr);
    wr_ack  <= wr_req;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: busy=%0d expected 0", busy);
    summary();
    $finish;
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_word = idx; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk); cfg_word = idx; #1 d = cfg_rdata;
  endtask

  task automatic put_w(input int a, input logic [31:0] v);
    for (int j = 0; j < 4; j++) mem[(a + j) & 2047] = v[8*j +: 8];
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, s, d, n, p, nx);
    put_w(a, c); put_w(a + 4, s); put_w(a + 8, d); put_w(a + 12, n); put_w(a + 16, p); put_w(a + 20, nx);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 5) & 255);
  endfunction

  task automatic fill();
    for (int i = 0; i < 128; i++) begin mem[SRC + i] = pat(i); mem[DST + i] = 8'h00; end
  endtask

  function automatic logic [31:0] mkcfg(input int sw, dw, sb, sf, df);
    return (32'(dw) << 25) | (32'd2 << 22) | (32'(df) << 21) | (32'd9 << 16) |
           (32'(sw) << 9) | (32'(sb) << 6) | (32'(sf) << 5) | 32'd4;
  endfunction

  task automatic run(input int base, output int cycles);
    int t0;
    reg_wr(4'd2, 32'(base));
    t0 = cyc;
    reg_wr(4'd0, 32'd1);
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    cycles = cyc - t0;
  endtask

  initial begin
    logic [31:0] v, l1, l2;
    int t, w1, w2, p0, q0, d0, cycles;
    int tb0 [0:3];
    logic [7:0] e [0:31];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      reg_rd(4'(i), v);
      chk("R2", $sformatf("reset readback idx %0d", i), v, 0);
    end
    chk("R2", "reset busy", busy, 0);

    // R3 R5 sweep of widths and address modes
    for (int sw = 0; sw < 4; sw++)
      for (int dw = 0; dw < 4; dw++)
        for (int sf = 0; sf < 2; sf++)
          for (int df = 0; df < 2; df++) begin
            int u, mn, nb;
            mn = (sw < dw) ? sw : dw;
            u = 1 << ((mn > 2) ? 2 : mn);
            nb = 16 / u;
            fill();
            put_desc(0, mkcfg(sw, dw, 1, sf, df), SRC, DST, 16, 0, ENDP);
            for (int i = 0; i < 32; i++) e[i] = 8'h00;
            for (int k = 0; k < nb; k++)
              for (int j = 0; j < u; j++) e[(df ? 0 : k * u) + j] = pat((sf ? 0 : k * u) + j);
            p0 = pkg_cnt; w1 = wr_cnt;
            run(0, cycles);
            t = 0;
            for (int i = 0; i < 32; i++) if (mem[DST + i] != e[i]) t++;
            chk("R5", $sformatf("dest bytes wrong sw%0d dw%0d sf%0d df%0d", sw, dw, sf, df), t, 0);
            chk("R3", $sformatf("beats sw%0d dw%0d", sw, dw), wr_cnt - w1, nb);
            reg_rd(4'd4, v); chk("R5", "final source address", v, sf ? SRC : SRC + 16);
            reg_rd(4'd5, v); chk("R5", "final dest address", v, df ? DST : DST + 16);
            reg_rd(4'd6, v); chk("R2", "bytes left", v, 0);
            chk("R7", "package pulses", pkg_cnt - p0, 1);
          end

    // R4 remainder beats
    fill();
    put_desc(0, mkcfg(2, 2, 0, 0, 0), SRC, DST, 7, 0, ENDP);
    w1 = wr_cnt;
    run(0, cycles);
    chk("R4", "beats for 7 bytes", wr_cnt - w1, 4);
    t = 0;
    for (int i = 0; i < 7; i++) if (mem[DST + i] != pat(i)) t++;
    chk("R4", "remainder bytes wrong", t, 0);
    chk("R4", "byte past count", mem[DST + 7], 0);

    // R6 burst grouping and wait cycles
    for (int sb = 0; sb < 4; sb++) begin
      int ta, tw;
      fill();
      put_desc(0, mkcfg(0, 0, sb, 0, 0), SRC, DST, 16, 32'hFFFF_FF00, ENDP);
      run(0, ta);
      tb0[sb] = ta;
      put_desc(0, mkcfg(0, 0, sb, 0, 0), SRC, DST, 16, 32'h0000_0003, ENDP);
      run(0, tw);
      chk("R6", $sformatf("wait cycles burst code %0d", sb), tw - ta, 3 * (16 / (sb == 0 ? 1 : (2 << sb)) - 1));
    end
    chk("R6", "no-wait time independent of burst", tb0[3], tb0[0]);

    // R1 R7 R8 R12 three-link chain
    fill();
    put_desc(32'h000, mkcfg(0, 0, 0, 0, 0), SRC, DST, 8, 0, 32'h040);
    put_desc(32'h040, mkcfg(2, 2, 0, 0, 0), SRC + 32, DST + 32, 12, 1, 32'h080);
    put_desc(32'h080, 32'h0A5F_00C3, 32'h0000_0123, 32'h0000_0456, 0, 32'h0000_1234, ENDP);
    p0 = pkg_cnt; q0 = qend_cnt; d0 = dsc_cnt;
    reg_wr(4'd2, 32'h000);
    reg_wr(4'd0, 32'd1);
    chk("R1", "busy after start", busy, 1);
    repeat (10) @(negedge clk);
    reg_wr(4'd0, 32'd1);
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    chk("R1", "descriptor words fetched", dsc_cnt - d0, 18);
    chk("R7", "chain package pulses", pkg_cnt - p0, 3);
    chk("R8", "queue end pulses", qend_cnt - q0, 1);
    chk("R12", "extra run write harmless", pkg_cnt - p0, 3);
    t = 0;
    for (int i = 0; i < 8; i++)  if (mem[DST + i] != pat(i)) t++;
    for (int i = 0; i < 12; i++) if (mem[DST + 32 + i] != pat(32 + i)) t++;
    chk("R8", "chain data wrong", t, 0);
    reg_rd(4'd0, v); chk("R8", "run bit after chain", v, 0);
    reg_rd(4'd3, v); chk("R2", "config readback", v, 32'h0A5F_00C3);
    reg_rd(4'd7, v); chk("R2", "parameter readback", v, 32'h0000_1234);
    reg_rd(4'd4, v); chk("R2", "zero-count source readback", v, 32'h123);
    reg_rd(4'd2, v); chk("R2", "start readback", v, 0);

    // R9 hold
    fill();
    put_desc(0, mkcfg(0, 0, 0, 0, 0), SRC, DST, 64, 0, ENDP);
    p0 = pkg_cnt;
    reg_wr(4'd2, 0); reg_wr(4'd0, 1);
    repeat (30) @(negedge clk);
    reg_wr(4'd1, 1);
    repeat (4) @(negedge clk);
    reg_rd(4'd6, l1); w1 = wr_cnt;
    repeat (40) @(negedge clk);
    reg_rd(4'd6, l2); w2 = wr_cnt;
    chk("R9", "bytes left during hold", l2, l1);
    chk("R9", "writes during hold", w2, w1);
    chk("R9", "hold mid-transfer", (l1 > 0 && l1 < 64) ? 1 : 0, 1);
    reg_rd(4'd1, v); chk("R2", "hold bit readback", v, 1);
    reg_wr(4'd1, 0);
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    t = 0;
    for (int i = 0; i < 64; i++) if (mem[DST + i] != pat(i)) t++;
    chk("R9", "data after resume", t, 0);
    chk("R9", "pulse after resume", pkg_cnt - p0, 1);

    // R10 stop
    fill();
    p0 = pkg_cnt;
    reg_wr(4'd0, 1);
    repeat (30) @(negedge clk);
    reg_wr(4'd0, 0);
    chk("R10", "busy after stop", busy, 0);
    reg_rd(4'd6, l1); w1 = wr_cnt;
    repeat (50) @(negedge clk);
    reg_rd(4'd6, l2); w2 = wr_cnt;
    chk("R10", "writes after stop", w2, w1);
    chk("R10", "bytes left frozen", l2, l1);
    chk("R10", "stopped part way", (l1 > 0) ? 1 : 0, 1);
    chk("R10", "no pulse after stop", pkg_cnt - p0, 0);
    reg_rd(4'd0, v); chk("R10", "run bit after stop", v, 0);

    chk("R11", "cycles with more than one request", multi_cnt, 0);
    summary();
    $finish;
  end
endmodule